// File: doc/BRIEF.md
# Auto-Incrementing Pointer Window

This block sits between a small processor's byte-wide data bus and a 16-bit memory space, and holds a set of address pointers (two by default). Each pointer owns a one-byte data window at a fixed bus address. A read or write to a window address is sent on to the location the pointer holds, not to the window address. When that pointer's increment bit is set, the pointer then steps forward by one. Software can therefore stream through a table, a buffer or a bank of control registers with repeated accesses to a single address.

A mode bit in the block's setup register decides who owns the window addresses. With the bit clear, accesses to those two addresses pass through to memory untouched. With the bit set, the block claims them.

A pointer may hold any 16-bit address, including the block's own setup and pointer registers. Such accesses are served inside the block and never reach memory.

The processor side uses a valid/ready request:
- A request is taken on a clock edge where `cpu_valid` and `cpu_ready` are both high.
- While `cpu_ready` is low, the processor must hold the address, write flag and data steady.
- `cpu_ready` follows `mem_ready` for accesses bound for memory. It is always high for accesses that land in the block's own registers.
- The memory side follows the same valid/ready rule. Memory returns read data one cycle after it accepts the request.
- Read responses have no back-pressure. `cpu_rvalid` pulses for one cycle, one cycle after the read was taken.

Top module: `ptrwin_top`

## Requirements
- R1: After reset the setup register and every pointer read as zero, and `cpu_rvalid` is low.
- R2: While the mode bit (setup bit 0) is clear, accesses to the window addresses (0xE67B for pointer 0, 0xE67C for pointer 1) go to memory at that same address, and no pointer changes.
- R3: While the mode bit is set, an access to a pointer's window goes to the address that pointer holds. The write data is passed on unchanged, and memory never sees the window address for that access.
- R4: After a window access is taken, the pointer advances by one if its increment bit is set (setup bit 1 for pointer 0, bit 2 for pointer 1). Otherwise the pointer keeps its value.
- R5: Incrementing from 0xFFFF gives 0x0000.
- R6: Register block at 0xE670 to 0xE674:
  - 0xE670 is the setup register.
  - 0xE671 and 0xE672 are the high and low bytes of pointer 0.
  - 0xE673 and 0xE674 are the high and low bytes of pointer 1.
  - Each byte can be written alone without touching the others, and each reads back what was written.
- R7: Read data and `cpu_rvalid` appear exactly one cycle after a read is taken, whether the data comes from memory or from the register block. No response follows a write.
- R8: Back-pressure works as follows:
  - A memory-bound request waits while `mem_ready` is low.
  - No pointer moves until its access is taken.
  - Register-block accesses are taken at once, whatever the state of `mem_ready`.
- R9: A window access whose pointer points into the register block is served inside the block and makes no memory access. A write through a window to one of that same pointer's bytes wins over the increment.
- R10: The pointers are independent. Accessing or writing one never changes another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Block can take the request this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor bus address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rvalid | output | 1 | Read response valid |
| cpu_rdata | output | 8 | Read response data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory can take the request |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | 16 | Memory address (pointer value or bus address) |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after acceptance |

## Verification
Three results have fixed timing relative to a request:
- The memory request, with its address and data, appears in the same cycle as the processor request. The bench's memory model records it at the edge where the request is taken.
- A pointer change is visible from the edge that takes the access. The bench confirms it by reading the pointer bytes back over the bus.
- Read data arrives exactly one cycle after that edge.

The driver samples `cpu_ready` just before each rising edge and counts stalled cycles. At the next falling edge it checks whether `cpu_rvalid` is high. A queue-based monitor matches each response, at the falling edge after it appears, against the value the bench's reference model predicted when the read was issued.

// File: rtl/ptrwin_pkg.sv
package ptrwin_pkg;
  localparam int PW_ADDR_W  = 16;
  localparam int PW_DATA_W  = 8;
  localparam int PW_NUM_PTR = 2;
  localparam logic [15:0] PW_REG_BASE = 16'hE670;
  localparam logic [15:0] PW_WIN_BASE = 16'hE67B;

  typedef enum logic {
    TGT_MEM = 1'b0,
    TGT_REG = 1'b1
  } tgt_e;
endpackage

// File: rtl/ptrwin_decode.sv
module ptrwin_decode
  import ptrwin_pkg::*;
#(
  parameter int ADDR_W  = PW_ADDR_W,
  parameter int NUM_PTR = PW_NUM_PTR,
  parameter int OFF_W   = 3,
  parameter logic [ADDR_W-1:0] REG_BASE = PW_REG_BASE,
  parameter logic [ADDR_W-1:0] WIN_BASE = PW_WIN_BASE
) (
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           mode,
  input  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_vals,
  output logic [ADDR_W-1:0]              eff_addr,
  output logic [NUM_PTR-1:0]             win_hit,
  output tgt_e                           target,
  output logic [OFF_W-1:0]               reg_off
);
  localparam int NUM_REGS = 1 + 2 * NUM_PTR;
  localparam logic [ADDR_W-1:0] REG_END = REG_BASE + ADDR_W'(NUM_REGS);

  logic [ADDR_W-1:0] rel;

  always_comb begin
    eff_addr = bus_addr;
    win_hit  = '0;
    for (int k = 0; k < NUM_PTR; k++) begin
      if (mode && (bus_addr == WIN_BASE + ADDR_W'(k))) begin
        win_hit[k] = 1'b1;
        eff_addr   = ptr_vals[k];
      end
    end
  end

  assign rel     = eff_addr - REG_BASE;
  assign reg_off = rel[OFF_W-1:0];
  assign target  = ((eff_addr >= REG_BASE) && (eff_addr < REG_END)) ? TGT_REG : TGT_MEM;
endmodule

// File: rtl/ptrwin_ptr.sv
module ptrwin_ptr #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic              inc,
  output logic [ADDR_W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (wr_hi) begin
      value[ADDR_W-1 -: DATA_W] <= wdata;
    end else if (wr_lo) begin
      value[DATA_W-1:0] <= wdata;
    end else if (inc) begin
      value <= value + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/ptrwin_ctrl.sv
module ptrwin_ctrl #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_PTR = 2,
  parameter int OFF_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           setup_wr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [OFF_W-1:0]               reg_off,
  input  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_vals,
  output logic                           mode,
  output logic [NUM_PTR-1:0]             inc_en,
  output logic [DATA_W-1:0]              reg_rdata
);
  localparam int SETUP_W = 1 + NUM_PTR;

  logic [SETUP_W-1:0] setup_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        setup_q <= '0;
    else if (setup_wr) setup_q <= wdata[SETUP_W-1:0];
  end

  assign mode   = setup_q[0];
  assign inc_en = setup_q[SETUP_W-1:1];

  always_comb begin
    reg_rdata = '0;
    if (reg_off == '0) reg_rdata = DATA_W'(setup_q);
    for (int k = 0; k < NUM_PTR; k++) begin
      if (reg_off == OFF_W'(1 + 2 * k)) reg_rdata = ptr_vals[k][ADDR_W-1 -: DATA_W];
      if (reg_off == OFF_W'(2 + 2 * k)) reg_rdata = ptr_vals[k][DATA_W-1:0];
    end
  end
endmodule

// File: rtl/ptrwin_top.sv
module ptrwin_top
  import ptrwin_pkg::*;
#(
  parameter int ADDR_W  = PW_ADDR_W,
  parameter int DATA_W  = PW_DATA_W,
  parameter int NUM_PTR = PW_NUM_PTR,
  parameter logic [ADDR_W-1:0] REG_BASE = PW_REG_BASE,
  parameter logic [ADDR_W-1:0] WIN_BASE = PW_WIN_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int NUM_REGS = 1 + 2 * NUM_PTR;
  localparam int OFF_W    = $clog2(NUM_REGS);

  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_vals;
  logic [NUM_PTR-1:0]             win_hit;
  logic [NUM_PTR-1:0]             inc_en;
  logic [ADDR_W-1:0]              eff_addr;
  logic [OFF_W-1:0]               reg_off;
  logic [DATA_W-1:0]              reg_rdata;
  tgt_e                           target;
  logic                           mode;
  logic                           take;
  logic                           reg_wr;
  logic                           rint_q;
  logic [DATA_W-1:0]              rreg_q;

  ptrwin_decode #(
    .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .OFF_W(OFF_W),
    .REG_BASE(REG_BASE), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .bus_addr(cpu_addr), .mode(mode), .ptr_vals(ptr_vals),
    .eff_addr(eff_addr), .win_hit(win_hit), .target(target), .reg_off(reg_off)
  );

  assign cpu_ready = (target == TGT_REG) || mem_ready;
  assign take      = cpu_valid && cpu_ready;
  assign reg_wr    = take && cpu_we && (target == TGT_REG);

  assign mem_valid = cpu_valid && (target == TGT_MEM);
  assign mem_we    = cpu_we;
  assign mem_addr  = eff_addr;
  assign mem_wdata = cpu_wdata;

  ptrwin_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PTR(NUM_PTR), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .setup_wr(reg_wr && (reg_off == '0)),
    .wdata(cpu_wdata), .reg_off(reg_off), .ptr_vals(ptr_vals),
    .mode(mode), .inc_en(inc_en), .reg_rdata(reg_rdata)
  );

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
    ptrwin_ptr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .wr_hi(reg_wr && (reg_off == OFF_W'(1 + 2 * k))),
      .wr_lo(reg_wr && (reg_off == OFF_W'(2 + 2 * k))),
      .wdata(cpu_wdata),
      .inc(take && win_hit[k] && inc_en[k]),
      .value(ptr_vals[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rvalid <= 1'b0;
      rint_q     <= 1'b0;
      rreg_q     <= '0;
    end else begin
      cpu_rvalid <= take && !cpu_we;
      if (take) begin
        rint_q <= (target == TGT_REG);
        rreg_q <= reg_rdata;
      end
    end
  end

  assign cpu_rdata = rint_q ? rreg_q : mem_rdata;
endmodule

// File: rtl/ptrwin_chk.sv
module ptrwin_chk
  import ptrwin_pkg::*;
#(
  parameter int ADDR_W  = PW_ADDR_W,
  parameter int NUM_PTR = PW_NUM_PTR
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           cpu_valid,
  input logic                           cpu_ready,
  input logic                           cpu_we,
  input logic [ADDR_W-1:0]              cpu_addr,
  input logic                           cpu_rvalid,
  input logic                           mem_valid,
  input logic [ADDR_W-1:0]              mem_addr,
  input logic                           mode,
  input logic                           inc0,
  input logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_vals
);
  logic take_rd, win0;
  assign take_rd = cpu_valid && cpu_ready && !cpu_we;
  assign win0    = (cpu_addr == ADDR_W'(PW_WIN_BASE));

  AST_RESP_DUE: assert property (@(posedge clk) disable iff (!rst_n) take_rd |=> cpu_rvalid); // R7
  AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n) !take_rd |=> !cpu_rvalid); // R7
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n) (cpu_valid && !mode && win0) |-> (mem_valid && mem_addr == cpu_addr)); // R2
  AST_WIN_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n) (cpu_valid && mode && win0 && mem_valid) |-> (mem_addr == ptr_vals[0])); // R3
  AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !(cpu_valid && cpu_ready) |=> $stable(ptr_vals)); // R8
  AST_REG_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (cpu_valid && !mem_valid) |-> cpu_ready); // R8
  AST_POST_INC: assert property (@(posedge clk) disable iff (!rst_n) (cpu_valid && cpu_ready && mode && win0 && inc0 && mem_valid) |=> (ptr_vals[0] == $past(ptr_vals[0]) + ADDR_W'(1))); // R4
  AST_NO_INC_OFF: assert property (@(posedge clk) disable iff (!rst_n) (cpu_valid && cpu_ready && mode && win0 && !inc0 && mem_valid) |=> $stable(ptr_vals[0])); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cpu_valid && cpu_ready && mode && win0 && inc0 && mem_valid && (&ptr_vals[0])) |=> (ptr_vals[0] == '0)); // R5
endmodule

bind ptrwin_top ptrwin_chk #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_rvalid(cpu_rvalid),
  .mem_valid(mem_valid), .mem_addr(mem_addr), .mode(mode),
  .inc0(inc_en[0]), .ptr_vals(ptr_vals)
);

// File: tb/ptrwin_top_test.sv
module ptrwin_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_ready, cpu_rvalid;
  logic [7:0]  cpu_rdata;
  logic        mem_valid, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ready = 1'b1;
  logic [7:0]  mem_rdata = '0;

  ptrwin_top uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // memory model
  logic [7:0] mem_m [logic [15:0]];
  int          mem_cnt = 0;
  logic [15:0] last_addr = '0;
  bit          stall_on = 0;
  int          stall_cnt = 0;

  function automatic logic [7:0] mem_peek(input logic [15:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return a[7:0] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_we) mem_m[mem_addr] = mem_wdata;
      else mem_rdata <= mem_peek(mem_addr);
      mem_cnt   = mem_cnt + 1;
      last_addr = mem_addr;
    end
    stall_cnt = stall_cnt + 1;
    mem_ready <= !stall_on || (stall_cnt % 3 == 0);
  end

  // reference model
  logic [7:0]  ref_setup = '0;
  logic [15:0] ref_ptr [2] = '{16'h0, 16'h0};

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always @(negedge clk) begin
    if (rst_n && cpu_rvalid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected response", {24'h0, cpu_rdata}, 32'h0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(cpu_rdata === e, t, {24'h0, cpu_rdata}, {24'h0, e});
      end
    end
  end

  task automatic acc(input bit we, input logic [15:0] addr, input logic [7:0] wd,
                     input string tag, output int waited);
    logic [15:0] eff;
    int win;
    bit intl, inc;
    logic [15:0] off;
    logic [7:0] expd;
    eff = addr; win = -1;
    if (ref_setup[0] && addr == 16'hE67B) begin eff = ref_ptr[0]; win = 0; end
    if (ref_setup[0] && addr == 16'hE67C) begin eff = ref_ptr[1]; win = 1; end
    intl = (eff >= 16'hE670) && (eff < 16'hE675);
    off  = eff - 16'hE670;
    if (intl) begin
      if (off == 0) expd = ref_setup;
      else if (off[0]) expd = ref_ptr[(off - 1) / 2][15:8];
      else expd = ref_ptr[(off - 1) / 2][7:0];
    end else expd = mem_peek(eff);
    inc = (win >= 0) && ref_setup[1 + win];
    if (inc && we && intl && (off == 16'(1 + 2 * win) || off == 16'(2 + 2 * win))) inc = 0;
    if (!we) begin exp_q.push_back(expd); tag_q.push_back(tag); end

    cpu_valid = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    waited = 0;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; waited++; end
    @(posedge clk);
    if (inc) ref_ptr[win] = ref_ptr[win] + 16'd1;
    if (we && intl) begin
      if (off == 0) ref_setup = {5'b0, wd[2:0]};
      else if (off[0]) ref_ptr[(off - 1) / 2][15:8] = wd;
      else ref_ptr[(off - 1) / 2][7:0] = wd;
    end
    @(negedge clk);
    cpu_valid = 0;
    chk(cpu_rvalid == !we, "R7 response timing", {31'h0, cpu_rvalid}, {31'h0, !we});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    int w;
    acc(1, a, d, tag, w);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    int w;
    acc(0, a, 8'h00, tag, w);
  endtask

  task automatic set_ptr(input int k, input logic [15:0] v);
    wr(16'(16'hE671 + 2 * k), v[15:8], "R6");
    wr(16'(16'hE672 + 2 * k), v[7:0], "R6");
  endtask

  task automatic read_ptr(input int k, input string tag);
    rd(16'(16'hE671 + 2 * k), tag);
    rd(16'(16'hE672 + 2 * k), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int w, cnt0;
    bit saw_stall;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(cpu_rvalid == 0, "R1 rvalid idle", {31'h0, cpu_rvalid}, 0);
    rd(16'hE670, "R1 setup reset");
    read_ptr(0, "R1 ptr0 reset");
    read_ptr(1, "R1 ptr1 reset");

    // R6 byte-wise pointer writes
    set_ptr(0, 16'h1234);
    wr(16'hE673, 8'hAB, "R6");
    read_ptr(0, "R6 ptr0 readback");
    read_ptr(1, "R6 ptr1 hi only");
    wr(16'h1234, 8'hA5, "R2 plain write");

    // R2 pass-through with mode clear
    cnt0 = mem_cnt;
    wr(16'hE67B, 8'h5C, "R2");
    chk(mem_cnt == cnt0 + 1 && last_addr == 16'hE67B, "R2 window addr to memory", {16'h0, last_addr}, 32'hE67B);
    chk(mem_peek(16'hE67B) == 8'h5C, "R2 data stored", {24'h0, mem_peek(16'hE67B)}, 32'h5C);
    rd(16'hE67C, "R2 read pass-through");
    read_ptr(0, "R2 ptr0 unchanged");

    // R3/R4 mode on, inc0 on, inc1 off
    wr(16'hE670, 8'h03, "R6 setup");
    rd(16'hE670, "R6 setup readback");
    rd(16'hE67B, "R3 window read");
    chk(last_addr == 16'h1234, "R3 redirect address", {16'h0, last_addr}, 32'h1234);
    wr(16'hE67B, 8'h77, "R3");
    chk(mem_peek(16'h1235) == 8'h77, "R3 window write data", {24'h0, mem_peek(16'h1235)}, 32'h77);
    chk(mem_peek(16'hE67B) == 8'h5C, "R3 window addr untouched", {24'h0, mem_peek(16'hE67B)}, 32'h5C);
    read_ptr(0, "R4 ptr0 incremented");

    set_ptr(1, 16'h4000);
    wr(16'hE67C, 8'h11, "R4");
    wr(16'hE67C, 8'h22, "R4");
    chk(mem_peek(16'h4000) == 8'h22, "R4 no-inc same location", {24'h0, mem_peek(16'h4000)}, 32'h22);
    read_ptr(1, "R4 ptr1 held");
    read_ptr(0, "R10 ptr0 unaffected");

    // R5 wrap
    set_ptr(0, 16'hFFFF);
    rd(16'hE67B, "R5 read at FFFF");
    read_ptr(0, "R5 wrapped to zero");
    rd(16'hE67B, "R5 read at 0000");

    // R8 back-pressure
    set_ptr(0, 16'h2000);
    stall_on = 1;
    saw_stall = 0;
    for (int i = 0; i < 6; i++) begin
      acc(0, 16'hE67B, 8'h00, "R8 stalled window read", w);
      if (w > 0) saw_stall = 1;
    end
    chk(saw_stall, "R8 stall observed", {31'h0, saw_stall}, 1);
    read_ptr(0, "R8 ptr advanced per accept");
    while (mem_ready) @(negedge clk);
    acc(0, 16'hE670, 8'h00, "R8 reg read", w);
    chk(w == 0, "R8 register access not stalled", w, 0);
    stall_on = 0;
    repeat (2) @(negedge clk);

    // R9 pointer aimed at own register block
    set_ptr(0, 16'hE672);
    cnt0 = mem_cnt;
    wr(16'hE67B, 8'h50, "R9");
    chk(mem_cnt == cnt0, "R9 no memory access", mem_cnt, cnt0);
    read_ptr(0, "R9 write beats increment");
    set_ptr(1, 16'hE670);
    rd(16'hE67C, "R9 window reads setup");
    chk(mem_cnt == cnt0, "R9 still no memory access", mem_cnt, cnt0);
    wr(16'hE670, 8'h05, "R10 setup");
    set_ptr(0, 16'h3000);
    set_ptr(1, 16'h3100);
    wr(16'hE67C, 8'h9A, "R10");
    rd(16'hE67B, "R10 ptr0 window");
    read_ptr(0, "R10 ptr0 held");
    read_ptr(1, "R10 ptr1 advanced");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all responses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule